// File: doc/BRIEF.md
# Two-way set-associative write-back cache controller

This block sits between a CPU request port and a slower main-memory port. CPU addresses are 24-bit byte addresses and every line holds one 4-byte block, so a line is exactly one 32-bit data word. The cache has two ways per set and a parameterised number of sets. A read or write that hits is served from the stored line. A miss first writes back a dirty victim if there is one, then fetches the block from memory, and then completes the access against the freshly installed line. The CPU holds its request until it sees a one-cycle ready pulse.

Two level inputs set the operating mode at run time. One selects write-back or write-through. The other turns the cache off, so that accesses go straight to memory. Two single-cycle commands perform maintenance. One discards every line at once. The other writes every dirty line back to memory and then discards all lines. The memory side moves one whole line per request/acknowledge handshake.

Top module: `cache2w_top`

## Requirements
- R1: After reset no line is valid, `busy`, `cpu_ready` and `mem_req` are low, and the first cached access to any address needs a memory fill.
- R2: Address bits [1:0] select a byte within the line and never affect line selection. The next SET_W bits form the set index and the remaining upper bits form the tag (9-bit tag and 13-bit set when SET_W is 13). `mem_addr` carries address bits [ADDR_W-1:2]. At most one way ever matches a lookup.
- R3: A cached read hit makes no memory transaction and returns the line on `cpu_rdata` together with a `cpu_ready` pulse that lasts exactly one cycle.
- R4: A cached read miss makes one memory read of the line, installs it, and returns its data.
- R5: An invalid way in the set is chosen as the victim first. Otherwise the victim is the way least recently used, where every hit and every fill counts as a use.
- R6: In write-back mode (`cfg_wback`=1), a cached write updates only the cache, marks the line dirty, and starts no memory transaction.
- R7: A dirty victim is written to memory before the fill read is issued, making two transactions. A clean victim is dropped with no write.
- R8: In write-through mode (`cfg_wback`=0), every cached write also sends the updated whole line to memory, and the line stays clean. A write miss first allocates the line by a fill.
- R9: On writes, `cpu_be` bit i selects byte i, data bits [8i+7:8i]. Bytes whose enable bit is clear keep their old value.
- R10: With `cfg_disable`=1, an access makes exactly one memory transaction at the line address: a write carries `cpu_be`, and a read returns the memory data. Cache contents are neither consulted nor changed.
- R11: A `cmd_inval` pulse while idle makes every line invalid in one cycle. Dirty data is discarded and no memory traffic results.
- R12: A `cmd_flush` pulse while idle writes each dirty line back exactly once and then makes every line invalid. `busy` stays high until this finishes. Flush takes priority over invalidate, and invalidate takes priority over a CPU request.
- R13: `mem_req` stays high with a stable address, direction and data until `mem_ack`. Each acknowledge completes exactly one line transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_be | input | 4 | Byte enables for writes |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` |
| cpu_ready | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Controller is not idle |
| cfg_disable | input | 1 | 1 = bypass the cache |
| cfg_wback | input | 1 | 1 = write-back, 0 = write-through |
| cmd_inval | input | 1 | Invalidate all lines |
| cmd_flush | input | 1 | Write back dirty lines, then invalidate all |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = line write, 0 = line read |
| mem_addr | output | ADDR_W-2 | Line address |
| mem_wdata | output | 32 | Line write data |
| mem_be | output | 4 | Byte enables of a memory write |
| mem_rdata | input | 32 | Line read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory completion pulse |

## Verification
The bench builds the block with SET_W=2, which gives four sets and an 20-bit tag. With so few sets, three tags aimed at one set force evictions after a handful of accesses. This brings LRU victim choice, dirty write-back ordering and flush walks over every set within reach. The memory model answers after a fixed delay and counts line transfers, so every access is judged both by its data and by the exact number of memory transactions the reference model predicts. Each configuration is exercised: write-back, write-through, disabled, invalidate and flush.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;

  localparam int N_WAYS  = 2;
  localparam int LINE_W  = 32;
  localparam int BYTES_W = LINE_W / 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WB,
    ST_FILL,
    ST_WT,
    ST_UNC,
    ST_RESP,
    ST_FLUSH
  } cstate_e;

  // byte-lane merge of new data into an old line
  function automatic logic [LINE_W-1:0] merge_bytes(input logic [LINE_W-1:0] old_line,
                                                    input logic [LINE_W-1:0] new_line,
                                                    input logic [BYTES_W-1:0] be);
    logic [LINE_W-1:0] r;
    for (int b = 0; b < BYTES_W; b++) begin
      r[8*b +: 8] = be[b] ? new_line[8*b +: 8] : old_line[8*b +: 8];
    end
    return r;
  endfunction

  // invalid way first, then the LRU pointer
  function automatic logic choose_victim(input logic v0, input logic v1, input logic lru);
    if (!v0)      return 1'b0;
    else if (!v1) return 1'b1;
    else          return lru;
  endfunction

endpackage

// File: rtl/cache2w_way.sv
module cache2w_way #(
  parameter int SET_W = 6,
  parameter int TAG_W = 16
) (
  input  logic                           clk,
  input  logic [SET_W-1:0]               set_i,
  output logic [TAG_W-1:0]               tag_o,
  output logic [cache2w_pkg::LINE_W-1:0] data_o,
  input  logic                           wr_en,
  input  logic [TAG_W-1:0]               wr_tag,
  input  logic [cache2w_pkg::LINE_W-1:0] wr_data
);
  localparam int NSETS = 1 << SET_W;

  logic [TAG_W-1:0]               tag_mem  [NSETS];
  logic [cache2w_pkg::LINE_W-1:0] data_mem [NSETS];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[set_i]  <= wr_tag;
      data_mem[set_i] <= wr_data;
    end
  end

  assign tag_o  = tag_mem[set_i];
  assign data_o = data_mem[set_i];
endmodule

// File: rtl/cache2w_meta.sv
module cache2w_meta #(
  parameter int SET_W = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [SET_W-1:0]              set_i,
  input  logic                          line_en,
  input  logic                          line_way,
  input  logic                          line_dirty,
  input  logic                          clean_en,
  input  logic                          clean_way,
  input  logic                          touch_en,
  input  logic                          touch_way,
  input  logic                          clear_all,
  output logic [1:0]                    vld_o,
  output logic [1:0]                    drt_o,
  output logic                          lru_o,
  output logic                          valid_any,
  output logic [2*(1<<SET_W)-1:0]       valid_flat
);
  localparam int NSETS = 1 << SET_W;

  logic [1:0][NSETS-1:0] valid_r;
  logic [1:0][NSETS-1:0] dirty_r;
  logic [NSETS-1:0]      lru_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_r <= '0;
      dirty_r <= '0;
      lru_r   <= '0;
    end else begin
      if (clear_all) begin
        valid_r <= '0;
        dirty_r <= '0;
      end else begin
        if (line_en) begin
          valid_r[line_way][set_i] <= 1'b1;
          dirty_r[line_way][set_i] <= line_dirty;
        end
        if (clean_en) dirty_r[clean_way][set_i] <= 1'b0;
      end
      if (touch_en) lru_r[set_i] <= ~touch_way;
    end
  end

  assign vld_o      = {valid_r[1][set_i], valid_r[0][set_i]};
  assign drt_o      = {dirty_r[1][set_i], dirty_r[0][set_i]};
  assign lru_o      = lru_r[set_i];
  assign valid_any  = |valid_r;
  assign valid_flat = valid_r;
endmodule

// File: rtl/cache2w_seq.sv
module cache2w_seq
  import cache2w_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int SET_W  = 6,
  parameter int TAG_W  = ADDR_W - SET_W - 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cpu_req,
  input  logic                   cpu_we,
  input  logic [ADDR_W-3:0]      cpu_line,
  input  logic [LINE_W-1:0]      cpu_wdata,
  input  logic [BYTES_W-1:0]     cpu_be,
  output logic [LINE_W-1:0]      cpu_rdata,
  output logic                   cpu_ready,
  output logic                   busy,
  input  logic                   cfg_disable,
  input  logic                   cfg_wback,
  input  logic                   cmd_inval,
  input  logic                   cmd_flush,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [ADDR_W-3:0]      mem_addr,
  output logic [LINE_W-1:0]      mem_wdata,
  output logic [BYTES_W-1:0]     mem_be,
  input  logic [LINE_W-1:0]      mem_rdata,
  input  logic                   mem_ack,
  // array side
  output logic [SET_W-1:0]       idx_o,
  input  logic [1:0][TAG_W-1:0]  tag_i,
  input  logic [1:0][LINE_W-1:0] data_i,
  output logic [1:0]             way_wr,
  output logic [TAG_W-1:0]       wr_tag,
  output logic [LINE_W-1:0]      wr_data,
  input  logic [1:0]             vld_i,
  input  logic [1:0]             drt_i,
  input  logic                   lru_i,
  output logic                   line_en,
  output logic                   line_way,
  output logic                   line_dirty,
  output logic                   clean_en,
  output logic                   clean_way,
  output logic                   touch_en,
  output logic                   touch_way,
  output logic                   clear_all,
  // named events for the checker
  output logic [1:0]             hit_vec,
  output logic                   ev_wr_wb_hit,
  output logic                   ev_wb_ack,
  output logic                   st_unc
);
  localparam int FIDX_W = SET_W + 1;

  cstate_e             st, nxt;
  logic                vic_q;
  logic [FIDX_W-1:0]   fidx_q;
  logic [LINE_W-1:0]   rdata_q, wt_q;
  logic                dis_q, wb_q;

  logic [SET_W-1:0]    cset;
  logic [TAG_W-1:0]    ctag;
  logic                hit, hway, victim, fway, fdirty, fadv;
  logic [LINE_W-1:0]   hdata, merged;

  assign cset   = cpu_line[SET_W-1:0];
  assign ctag   = cpu_line[ADDR_W-3:SET_W];
  assign idx_o  = (st == ST_FLUSH) ? fidx_q[FIDX_W-1:1] : cset;
  assign fway   = fidx_q[0];

  assign hit_vec = {vld_i[1] && (tag_i[1] == ctag), vld_i[0] && (tag_i[0] == ctag)};
  assign hit     = |hit_vec;
  assign hway    = hit_vec[1];
  assign hdata   = data_i[hway];
  assign merged  = merge_bytes(hdata, cpu_wdata, cpu_be);
  assign victim  = choose_victim(vld_i[0], vld_i[1], lru_i);
  assign fdirty  = vld_i[fway] && drt_i[fway];
  assign fadv    = (st == ST_FLUSH) && (!fdirty || mem_ack);

  always_comb begin
    nxt        = st;
    mem_req    = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = cpu_line;
    mem_wdata  = cpu_wdata;
    mem_be     = '1;
    way_wr     = '0;
    wr_tag     = ctag;
    wr_data    = mem_rdata;
    line_en    = 1'b0;
    line_way   = 1'b0;
    line_dirty = 1'b0;
    clean_en   = 1'b0;
    clean_way  = fway;
    touch_en   = 1'b0;
    touch_way  = 1'b0;
    clear_all  = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (cmd_flush)      nxt = ST_FLUSH;
        else if (cmd_inval) clear_all = 1'b1;
        else if (cpu_req)   nxt = cfg_disable ? ST_UNC : ST_LOOK;
      end
      ST_LOOK: begin
        if (hit) begin
          touch_en  = 1'b1;
          touch_way = hway;
          if (cpu_we) begin
            way_wr[hway] = 1'b1;
            wr_data      = merged;
            line_en      = 1'b1;
            line_way     = hway;
            line_dirty   = wb_q;
            nxt          = wb_q ? ST_RESP : ST_WT;
          end else begin
            nxt = ST_RESP;
          end
        end else begin
          nxt = (vld_i[victim] && drt_i[victim]) ? ST_WB : ST_FILL;
        end
      end
      ST_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {tag_i[vic_q], cset};
        mem_wdata = data_i[vic_q];
        if (mem_ack) nxt = ST_FILL;
      end
      ST_FILL: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          way_wr[vic_q] = 1'b1;
          line_en       = 1'b1;
          line_way      = vic_q;
          touch_en      = 1'b1;
          touch_way     = vic_q;
          nxt           = ST_LOOK;
        end
      end
      ST_WT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = wt_q;
        if (mem_ack) nxt = ST_RESP;
      end
      ST_UNC: begin
        mem_req = 1'b1;
        mem_we  = cpu_we;
        mem_be  = cpu_we ? cpu_be : '1;
        if (mem_ack) nxt = ST_RESP;
      end
      ST_RESP: nxt = ST_IDLE;
      ST_FLUSH: begin
        if (fdirty) begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = {tag_i[fway], idx_o};
          mem_wdata = data_i[fway];
          clean_en  = mem_ack;
        end
        if (fadv && (fidx_q == '1)) begin
          clear_all = 1'b1;
          nxt       = ST_IDLE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      vic_q   <= 1'b0;
      fidx_q  <= '0;
      rdata_q <= '0;
      wt_q    <= '0;
      dis_q   <= 1'b0;
      wb_q    <= 1'b1;
    end else begin
      st <= nxt;
      case (st)
        ST_IDLE: begin
          if (cmd_flush) fidx_q <= '0;
          else if (!cmd_inval && cpu_req) begin
            dis_q <= cfg_disable;
            wb_q  <= cfg_wback;
          end
        end
        ST_LOOK: begin
          if (hit && !cpu_we) rdata_q <= hdata;
          if (hit && cpu_we)  wt_q    <= merged;
          if (!hit)           vic_q   <= victim;
        end
        ST_UNC:   if (mem_ack) rdata_q <= mem_rdata;
        ST_FLUSH: if (fadv) fidx_q <= fidx_q + 1'b1;
        default: ;
      endcase
    end
  end

  assign cpu_rdata    = rdata_q;
  assign cpu_ready    = (st == ST_RESP);
  assign busy         = (st != ST_IDLE);
  assign ev_wr_wb_hit = (st == ST_LOOK) && hit && cpu_we && wb_q;
  assign ev_wb_ack    = (st == ST_WB) && mem_ack;
  assign st_unc       = (st == ST_UNC) && dis_q;
endmodule

// File: rtl/cache2w_top.sv
module cache2w_top
  import cache2w_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int SET_W  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_req,
  input  logic                cpu_we,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [31:0]         cpu_wdata,
  input  logic [3:0]          cpu_be,
  output logic [31:0]         cpu_rdata,
  output logic                cpu_ready,
  output logic                busy,
  input  logic                cfg_disable,
  input  logic                cfg_wback,
  input  logic                cmd_inval,
  input  logic                cmd_flush,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-3:0]   mem_addr,
  output logic [31:0]         mem_wdata,
  output logic [3:0]          mem_be,
  input  logic [31:0]         mem_rdata,
  input  logic                mem_ack
);
  localparam int TAG_W  = ADDR_W - SET_W - 2;
  localparam int NSETS  = 1 << SET_W;

  logic                   unused_offset;
  logic [SET_W-1:0]       idx;
  logic [1:0][TAG_W-1:0]  way_tag;
  logic [1:0][LINE_W-1:0] way_data;
  logic [1:0]             way_wr;
  logic [TAG_W-1:0]       wr_tag;
  logic [LINE_W-1:0]      wr_data;
  logic [1:0]             vld, drt;
  logic                   lru;
  logic                   line_en, line_way, line_dirty;
  logic                   clean_en, clean_way, touch_en, touch_way, clear_all;
  logic                   valid_any;
  logic [2*NSETS-1:0]     valid_flat;
  logic [1:0]             hit_vec;
  logic                   ev_wr_wb_hit, ev_wb_ack, st_unc;

  assign unused_offset = ^cpu_addr[1:0];

  for (genvar w = 0; w < N_WAYS; w++) begin : g_way
    cache2w_way #(.SET_W(SET_W), .TAG_W(TAG_W)) u_way (
      .clk     (clk),
      .set_i   (idx),
      .tag_o   (way_tag[w]),
      .data_o  (way_data[w]),
      .wr_en   (way_wr[w]),
      .wr_tag  (wr_tag),
      .wr_data (wr_data)
    );
  end

  cache2w_meta #(.SET_W(SET_W)) u_meta (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (idx),
    .line_en    (line_en),
    .line_way   (line_way),
    .line_dirty (line_dirty),
    .clean_en   (clean_en),
    .clean_way  (clean_way),
    .touch_en   (touch_en),
    .touch_way  (touch_way),
    .clear_all  (clear_all),
    .vld_o      (vld),
    .drt_o      (drt),
    .lru_o      (lru),
    .valid_any  (valid_any),
    .valid_flat (valid_flat)
  );

  cache2w_seq #(.ADDR_W(ADDR_W), .SET_W(SET_W), .TAG_W(TAG_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_req      (cpu_req),
    .cpu_we       (cpu_we),
    .cpu_line     (cpu_addr[ADDR_W-1:2]),
    .cpu_wdata    (cpu_wdata),
    .cpu_be       (cpu_be),
    .cpu_rdata    (cpu_rdata),
    .cpu_ready    (cpu_ready),
    .busy         (busy),
    .cfg_disable  (cfg_disable),
    .cfg_wback    (cfg_wback),
    .cmd_inval    (cmd_inval),
    .cmd_flush    (cmd_flush),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_be       (mem_be),
    .mem_rdata    (mem_rdata),
    .mem_ack      (mem_ack),
    .idx_o        (idx),
    .tag_i        (way_tag),
    .data_i       (way_data),
    .way_wr       (way_wr),
    .wr_tag       (wr_tag),
    .wr_data      (wr_data),
    .vld_i        (vld),
    .drt_i        (drt),
    .lru_i        (lru),
    .line_en      (line_en),
    .line_way     (line_way),
    .line_dirty   (line_dirty),
    .clean_en     (clean_en),
    .clean_way    (clean_way),
    .touch_en     (touch_en),
    .touch_way    (touch_way),
    .clear_all    (clear_all),
    .hit_vec      (hit_vec),
    .ev_wr_wb_hit (ev_wr_wb_hit),
    .ev_wb_ack    (ev_wb_ack),
    .st_unc       (st_unc)
  );
endmodule

// File: rtl/cache2w_checker.sv
module cache2w_checker #(
  parameter int LINE_AW = 22,
  parameter int VF_W    = 128
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cpu_ready,
  input logic               busy,
  input logic               cmd_inval,
  input logic               cmd_flush,
  input logic               mem_req,
  input logic               mem_we,
  input logic               mem_ack,
  input logic [LINE_AW-1:0] mem_addr,
  input logic [31:0]        mem_wdata,
  input logic [1:0]         hit_vec,
  input logic               ev_wr_wb_hit,
  input logic               ev_wb_ack,
  input logic               st_unc,
  input logic               valid_any,
  input logic [VF_W-1:0]    valid_flat
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !cpu_ready));

  a_r2_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  a_r3_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

  a_r6_no_traffic: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_wb_hit |=> !mem_req);

  a_r7_fill_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wb_ack |=> (mem_req && !mem_we));

  a_r10_bypass_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    st_unc |=> $stable(valid_flat));

  a_r11_inval_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_inval && !cmd_flush) |=> !valid_any);

  a_r12_flush_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_flush) |=> busy);

  a_r13_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
endmodule

bind cache2w_top cache2w_checker #(.LINE_AW(ADDR_W-2), .VF_W(2*(1<<SET_W))) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_ready    (cpu_ready),
  .busy         (busy),
  .cmd_inval    (cmd_inval),
  .cmd_flush    (cmd_flush),
  .mem_req      (mem_req),
  .mem_we       (mem_we),
  .mem_ack      (mem_ack),
  .mem_addr     (mem_addr),
  .mem_wdata    (mem_wdata),
  .hit_vec      (hit_vec),
  .ev_wr_wb_hit (ev_wr_wb_hit),
  .ev_wb_ack    (ev_wb_ack),
  .st_unc       (st_unc),
  .valid_any    (valid_any),
  .valid_flat   (valid_flat)
);

// File: tb/test_cache2w_top.sv
module test_cache2w_top;
  localparam int ADDR_W = 24;
  localparam int SET_W  = 2;
  localparam int NSETS  = 1 << SET_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req = 0, cpu_we = 0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [3:0]  cpu_be = '0;
  logic [31:0] cpu_rdata;
  logic cpu_ready, busy;
  logic cfg_disable = 0, cfg_wback = 1, cmd_inval = 0, cmd_flush = 0;
  logic mem_req, mem_we;
  logic [ADDR_W-3:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [3:0]  mem_be;
  logic [31:0] mem_rdata = '0;
  logic mem_ack = 1'b0;

  always #5 clk = ~clk;

  cache2w_top #(.ADDR_W(ADDR_W), .SET_W(SET_W)) i_cache2w_top (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .busy(busy), .cfg_disable(cfg_disable), .cfg_wback(cfg_wback), .cmd_inval(cmd_inval),
    .cmd_flush(cmd_flush), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int txn     = 0;
  int rcnt    = 0;

  logic [31:0] mem_img [int];   // memory seen through the memory port
  logic [31:0] exp_mem [int];   // memory the reference model predicts
  logic [31:0] cdata   [int];   // reference cached copies, keyed by line
  bit          cdirty  [int];
  int          mq [NSETS][$];   // per set: front is least recently used

  function automatic logic [31:0] seed_val(int line);
    return (32'(line) * 32'h0103_0507) ^ 32'hC3C3_0000;
  endfunction

  function automatic logic [31:0] bmerge(logic [31:0] o, logic [31:0] n, logic [3:0] be);
    logic [31:0] r;
    r = o;
    for (int i = 0; i < 4; i++) if (be[i]) r[i*8 +: 8] = n[i*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] img_rd(int line);
    return mem_img.exists(line) ? mem_img[line] : seed_val(line);
  endfunction

  function automatic logic [31:0] exp_rd(int line);
    return exp_mem.exists(line) ? exp_mem[line] : seed_val(line);
  endfunction

  // memory responder: answers two cycles after a request is seen
  always @(negedge clk) begin
    int ln;
    if (!rst_n) begin
      mem_ack = 1'b0;
      rcnt = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      rcnt++;
      if (rcnt == 2) begin
        rcnt = 0;
        txn++;
        ln = int'(mem_addr);
        if (mem_we) mem_img[ln] = bmerge(img_rd(ln), mem_wdata, mem_be);
        else        mem_rdata = img_rd(ln);
        mem_ack = 1'b1;
      end
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic model_cached(int line, bit we, logic [31:0] wd, logic [3:0] be, bit wbm,
                              output int et, output logic [31:0] er);
    int s, pos, vic;
    s = line % NSETS;
    pos = -1;
    et = 0;
    foreach (mq[s][i]) if (mq[s][i] == line) pos = i;
    if (pos >= 0) begin
      mq[s].delete(pos);
    end else begin
      et = 1;
      if (mq[s].size() == 2) begin
        vic = mq[s].pop_front();
        if (cdirty[vic]) begin
          et++;
          exp_mem[vic] = cdata[vic];
        end
        cdata.delete(vic);
        cdirty.delete(vic);
      end
      cdata[line]  = exp_rd(line);
      cdirty[line] = 1'b0;
    end
    mq[s].push_back(line);
    if (we) begin
      cdata[line] = bmerge(cdata[line], wd, be);
      if (wbm) cdirty[line] = 1'b1;
      else begin
        exp_mem[line] = cdata[line];
        et++;
      end
    end
    er = cdata[line];
  endtask

  task automatic access(string what, int line, int off, bit we, logic [31:0] wd,
                        logic [3:0] be, bit dis, bit wbm);
    int et;
    logic [31:0] er, got;
    er = '0;
    if (dis) begin
      et = 1;
      if (we) exp_mem[line] = bmerge(exp_rd(line), wd, be);
      else    er = exp_rd(line);
    end else begin
      model_cached(line, we, wd, be, wbm, et, er);
    end
    @(negedge clk);
    cfg_disable = dis;
    cfg_wback   = wbm;
    cpu_we      = we;
    cpu_addr    = ADDR_W'((line << 2) | off);
    cpu_wdata   = wd;
    cpu_be      = be;
    cpu_req     = 1'b1;
    txn         = 0;
    do @(negedge clk); while (!cpu_ready);
    got = cpu_rdata;
    cpu_req = 1'b0;
    if (!we) chk({what, " read data"}, got, er);
    chk({what, " memory transactions (R13 one per ack)"}, 32'(txn), 32'(et));
  endtask

  task automatic command(string what, bit fl);
    int et;
    et = 0;
    if (fl) begin
      for (int s = 0; s < NSETS; s++)
        foreach (mq[s][i])
          if (cdirty[mq[s][i]]) begin
            exp_mem[mq[s][i]] = cdata[mq[s][i]];
            et++;
          end
    end
    for (int s = 0; s < NSETS; s++) mq[s].delete();
    cdata.delete();
    cdirty.delete();
    @(negedge clk);
    cmd_flush = fl;
    cmd_inval = !fl;
    txn = 0;
    @(negedge clk);
    cmd_flush = 1'b0;
    cmd_inval = 1'b0;
    while (busy) @(negedge clk);
    chk({what, " memory transactions"}, 32'(txn), 32'(et));
  endtask

  task automatic mem_chk(string what, int line);
    chk(what, img_rd(line), exp_rd(line));
  endtask

  localparam int LA = 4, LB = 8, LC = 12;   // set 0, tags 1..3
  localparam int LD = 5;                    // set 1
  localparam int LE = 10, LF = 14;          // set 2
  localparam int LG = 27;                   // set 3

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after reset", 32'(busy), 32'd0);
        chk("R1 cpu_ready after reset", 32'(cpu_ready), 32'd0);
        chk("R1 mem_req after reset", 32'(mem_req), 32'd0);

        access("R1 R4 read miss A", LA, 0, 0, 0, 4'h0, 0, 1);
        access("R3 read hit A", LA, 0, 0, 0, 4'h0, 0, 1);
        access("R2 offset bits ignored A", LA, 3, 0, 0, 4'h0, 0, 1);
        access("R6 write-back hit A", LA, 0, 1, 32'hDEAD_BEEF, 4'hF, 0, 1);
        mem_chk("R6 memory untouched by write-back", LA);
        access("R6 read back A", LA, 0, 0, 0, 4'h0, 0, 1);
        access("R9 byte-enable write A", LA, 1, 1, 32'h1122_3344, 4'b0101, 0, 1);
        access("R9 read merged A", LA, 0, 0, 0, 4'h0, 0, 1);
        access("R5 R4 miss B into free way", LB, 0, 0, 0, 4'h0, 0, 1);
        access("R5 touch A", LA, 0, 0, 0, 4'h0, 0, 1);
        access("R5 R7 miss C evicts clean B", LC, 0, 0, 0, 4'h0, 0, 1);
        access("R7 miss B evicts dirty A", LB, 0, 0, 0, 4'h0, 0, 1);
        mem_chk("R7 dirty A written back", LA);
        access("R8 write-through hit B", LB, 0, 1, 32'h0BAD_F00D, 4'hF, 0, 0);
        mem_chk("R8 memory updated at once", LB);
        access("R8 write-through miss D", LD, 0, 1, 32'h5555_AAAA, 4'b0011, 0, 0);
        mem_chk("R8 R9 memory line D", LD);
        access("R10 uncached read E", LE, 0, 0, 0, 4'h0, 1, 1);
        access("R10 no allocation on E", LE, 0, 0, 0, 4'h0, 0, 1);
        access("R10 R9 uncached write F", LF, 2, 1, 32'hCAFE_0123, 4'b1100, 1, 1);
        mem_chk("R10 uncached write in memory", LF);
        access("R11 dirty write G", LG, 0, 1, 32'h7777_7777, 4'hF, 0, 1);
        command("R11 invalidate", 1'b0);
        access("R11 G refetched without write", LG, 0, 0, 0, 4'h0, 0, 1);
        access("R12 dirty write 9", 9, 0, 1, 32'h9999_0009, 4'hF, 0, 1);
        access("R12 dirty write 19", 19, 0, 1, 32'h1919_0019, 4'hF, 0, 1);
        access("R12 dirty write 6", 6, 0, 1, 32'h0606_0006, 4'b0110, 0, 1);
        command("R12 flush", 1'b1);
        mem_chk("R12 line 9 flushed", 9);
        mem_chk("R12 line 19 flushed", 19);
        mem_chk("R12 line 6 flushed", 6);
        mem_chk("R12 clean line D untouched", LD);
        access("R12 miss after flush", 9, 0, 0, 0, 4'h0, 0, 1);
      end
      begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule